// File: doc/BRIEF.md
# Sequential Multiplier with Leading-Zero Skip

This block forms the unsigned double-width product of two W-bit operands, the multiplicand and the multiplier, over several clock cycles. A one-cycle start strobe hands both operands to the block. Some time later a one-cycle done strobe marks the moment when the low and high product words become valid. The product words then keep their value until the next done.

A multiplier of zero takes a short path and never enters the loop. For any other multiplier, a skip phase first shifts out the leading zeros of the multiplier, one per cycle. The first 1 bit found copies the multiplicand straight into the partial product. A main phase then walks the remaining bits from the most significant end. On each bit it doubles the partial product and adds the multiplicand when the bit is 1. When the multiplier is loaded, a marker 1 is placed below its least significant bit. Each shift moves that marker up by one place. The loop ends when the marker is the only bit left, so no bit counter is needed.

Top module: `lzskip_mul`

## Requirements
- R1: While reset is held and right after it is released, `done` and `busy` are 0 and both product words are 0.
- R2: For an accepted start, {`prod_hi`,`prod_lo`} equals the unsigned product `mcand` × `mplier`. `prod_lo` holds bits W-1:0 and `prod_hi` holds bits 2W-1:W.
- R3: A start with `mplier` equal to 0 gives `done` in the cycle right after the accepting edge, with both product words 0. `busy` never goes high for it.
- R4: A start with a nonzero `mplier` keeps `busy` high from the accepting edge on, for W+1 edges. `done` rises after the (W+1)-th edge following the accepting edge, whatever the number of leading zeros.
- R5: `done` is high for exactly one cycle per accepted start, and `busy` is low whenever `done` is high.
- R6: A start that arrives while `busy` is high is ignored. It neither changes the result of the running operation nor produces an extra `done`.
- R7: The product words change only in a cycle where `done` is high, and they hold their value between results.
- R8: A start given in the same cycle as `done` is accepted, so operations can run back to back.
- R9: Corner operands give correct products with the R4 latency: multiplier 1 (all leading zeros skipped), multiplier with its MSB set (no skip), zero multiplicand, and all-ones operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request, taken only while idle |
| mcand | input | W | Multiplicand, sampled with an accepted start |
| mplier | input | W | Multiplier, sampled with an accepted start |
| busy | output | 1 | An operation is in its skip or main phase |
| done | output | 1 | One-cycle strobe: product words valid |
| prod_lo | output | W | Low word of the product |
| prod_hi | output | W | High word of the product |

## Verification
Results arrive at one of two fixed delays, counted from the edge that accepts the start. A zero multiplier raises `done` right after that edge. Any other multiplier raises it W+1 edges later, whether the leading zeros are many or none. The bench drives and samples at falling edges. It counts the falling edges that pass until `done` is seen, compares that count with the delay expected for the multiplier, and reads the product in that same cycle. It then watches a few more cycles to confirm that no second strobe appears and that the words hold.

// File: rtl/lzm_pkg.sv
package lzm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SKIP = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;
endpackage

// File: rtl/lzm_mpr.sv
// Multiplier shift register: W data bits plus a marker 1 below them.
module lzm_mpr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] value,
  output logic         top_bit,
  output logic         marker_only
);
  localparam int RW = W + 1;
  localparam logic [RW-1:0] MARKER_AT_TOP = {1'b1, {W{1'b0}}};

  logic [RW-1:0] mr;

  function automatic logic [RW-1:0] seed(input logic [W-1:0] v);
    return {v, 1'b1};
  endfunction

  function automatic logic [RW-1:0] shl(input logic [RW-1:0] v);
    return {v[RW-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     mr <= '0;
    else if (load)  mr <= seed(value);
    else if (shift) mr <= shl(mr);
  end

  assign top_bit     = mr[RW-1];
  assign marker_only = (mr == MARKER_AT_TOP);
endmodule

// File: rtl/lzm_acc.sv
// Partial-product accumulator with its captured multiplicand.
module lzm_acc #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic [W-1:0]   mcand,
  input  logic           first,
  input  logic           step,
  input  logic           add_en,
  output logic [2*W-1:0] acc
);
  localparam int PW = 2 * W;

  logic [W-1:0] mc;

  function automatic logic [PW-1:0] widen(input logic [W-1:0] v);
    return {{W{1'b0}}, v};
  endfunction

  function automatic logic [PW-1:0] next_acc(input logic [PW-1:0] a,
                                             input logic [W-1:0]  m,
                                             input logic          add);
    return (a << 1) + (add ? widen(m) : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       mc <= '0;
    else if (capture) mc <= mcand;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (first) acc <= widen(mc);
    else if (step)  acc <= next_acc(acc, mc, add_en);
  end
endmodule

// File: rtl/lzm_ctrl.sv
// Phase sequencing: idle, leading-zero skip, main loop.
module lzm_ctrl
  import lzm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   mplier_zero,
  input  logic   top_bit,
  input  logic   marker_only,
  output phase_t phase,
  output logic   accept,
  output logic   zero_hit,
  output logic   load,
  output logic   skip_shift,
  output logic   first_one,
  output logic   run_step,
  output logic   finish
);
  phase_t phase_nx;

  always_comb begin
    accept     = start && (phase == PH_IDLE);
    zero_hit   = accept && mplier_zero;
    load       = accept && !mplier_zero;
    skip_shift = (phase == PH_SKIP) && !top_bit;
    first_one  = (phase == PH_SKIP) && top_bit;
    run_step   = (phase == PH_RUN) && !marker_only;
    finish     = (phase == PH_RUN) && marker_only;
  end

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE: if (load)      phase_nx = PH_SKIP;
      PH_SKIP: if (first_one) phase_nx = PH_RUN;
      PH_RUN:  if (finish)    phase_nx = PH_IDLE;
      default:                phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/lzskip_mul.sv
module lzskip_mul
  import lzm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi
);
  localparam int PW = 2 * W;

  phase_t        phase;
  logic          accept, zero_hit, load, skip_shift, first_one, run_step, finish;
  logic          top_bit, marker_only, mpr_shift;
  logic [PW-1:0] acc;

  lzm_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mplier_zero (mplier == '0),
    .top_bit     (top_bit),
    .marker_only (marker_only),
    .phase       (phase),
    .accept      (accept),
    .zero_hit    (zero_hit),
    .load        (load),
    .skip_shift  (skip_shift),
    .first_one   (first_one),
    .run_step    (run_step),
    .finish      (finish)
  );

  assign mpr_shift = skip_shift | first_one | run_step;

  lzm_mpr #(.W(W)) u_mpr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .shift       (mpr_shift),
    .value       (mplier),
    .top_bit     (top_bit),
    .marker_only (marker_only)
  );

  lzm_acc #(.W(W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (load),
    .mcand   (mcand),
    .first   (first_one),
    .step    (run_step),
    .add_en  (top_bit),
    .acc     (acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      prod_lo <= '0;
      prod_hi <= '0;
    end else begin
      done <= zero_hit | finish;
      if (zero_hit) begin
        prod_lo <= '0;
        prod_hi <= '0;
      end else if (finish) begin
        prod_lo <= acc[W-1:0];
        prod_hi <= acc[PW-1:W];
      end
    end
  end

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/lzm_chk.sv
module lzm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_lo,
  input logic [W-1:0] prod_hi,
  input logic         accept,
  input logic         zero_hit,
  input logic         first_one,
  input logic         finish
);
  localparam int CW = $clog2(W + 2) + 1;

  logic [CW-1:0] since_accept;

  always_ff @(posedge clk) begin
    if (!rst_n)      since_accept <= '0;
    else if (accept) since_accept <= '0;
    else if (busy)   since_accept <= since_accept + 1'b1;
  end

  AST_ZERO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> (done && !busy && prod_lo == '0 && prod_hi == '0)); // R3

  AST_FINISH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (since_accept == CW'(W))); // R4

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !zero_hit) |=> busy); // R4

  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    first_one |=> !first_one); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !accept); // R6

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({prod_hi, prod_lo})); // R7
endmodule

bind lzskip_mul lzm_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .prod_lo   (prod_lo),
  .prod_hi   (prod_hi),
  .accept    (accept),
  .zero_hit  (zero_hit),
  .first_one (first_one),
  .finish    (finish)
);

// File: tb/lzskip_mul_tb.sv
module lzskip_mul_tb;
  localparam int W   = 16;
  localparam int PER = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         busy, done;
  logic [W-1:0] prod_lo, prod_hi;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  lzskip_mul #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .prod_lo(prod_lo), .prod_hi(prod_hi)
  );

  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] wa, wb;
    wa = {{W{1'b0}}, a};
    wb = {{W{1'b0}}, b};
    return wa * wb;
  endfunction

  function automatic int ref_lat(input logic [W-1:0] b);
    return (b == '0) ? 0 : W + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where done is seen.
  task automatic op(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string req);
    int n;
    int busy_low;
    logic [2*W-1:0] got;
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    n = 0; busy_low = 0;
    while (!done && n < 4 * W) begin
      if (!busy) busy_low++;
      if (poke && n == 3) begin
        start = 1'b1; mcand = ~a; mplier = b ^ 16'h5a5b;   // R6 stimulus while busy
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    got = {prod_hi, prod_lo};
    chk(n == ref_lat(b), (b == 0) ? "R3 latency" : "R4 latency", n, ref_lat(b));
    chk(got == ref_prod(a, b), req, got, ref_prod(a, b));
    if (b == 0) chk(busy_low == 0 && !busy, "R3 busy stays low", busy, 0);
    else        chk(busy_low == 0 && !busy, "R4 busy high until done", busy_low, 0);
  endtask

  task automatic quiet(input int cycles, input string req);
    logic [2*W-1:0] held;
    held = {prod_hi, prod_lo};
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(!done, {req, " no extra done"}, done, 0);
      chk({prod_hi, prod_lo} == held, "R7 words held", {prod_hi, prod_lo}, held);
    end
  endtask

  initial begin
    @(negedge clk);
    chk(!done && !busy && prod_lo == 0 && prod_hi == 0, "R1 in reset", {done, busy}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && {prod_hi, prod_lo} == 0, "R1 after reset", {prod_hi, prod_lo}, 0);

    // R9 corner cases
    op(16'h1234, 16'h0001, 0, "R9 mplier one");
    quiet(2, "R5");
    op(16'hbeef, 16'h8000, 0, "R9 mplier msb");
    quiet(1, "R5");
    op(16'h0000, 16'h7fff, 0, "R9 zero mcand");
    op(16'hffff, 16'hffff, 0, "R9 all ones");
    quiet(1, "R5");
    // R3 zero multiplier
    op(16'habcd, 16'h0000, 0, "R3 zero product");
    quiet(2, "R5");
    // R6 start while busy
    op(16'h0f0f, 16'h00c3, 1, "R6 result unaffected");
    quiet(4, "R6");
    // R8 back to back: each op begins at the falling edge where done was seen
    op(16'h1111, 16'h2222, 0, "R8 first");
    op(16'h3333, 16'h0000, 0, "R8 second zero");
    op(16'h5555, 16'h0404, 0, "R8 third");
    quiet(1, "R5");

    // R2 random vectors with a fixed seed
    void'($urandom(32'd1357));
    for (int k = 0; k < 60; k++) begin
      logic [W-1:0] a, b;
      a = W'($urandom());
      b = W'($urandom());
      if (k % 7 == 0) b = b >> (k % W);
      if (k % 11 == 0) b = '0;
      op(a, b, (k % 9 == 0), "R2 random product");
      if (k % 3 == 0) quiet(1, "R5");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(PER * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule